// File: doc/BRIEF.md
# Microcoded Control Sequencer for a Multicycle Processor

This block drives the control lines of a multicycle datapath that executes register-register arithmetic, word load, word store, branch-if-equal and unconditional jump. Each clock cycle the block reads one microword from a small on-chip store. The microword sets the datapath controls for that cycle and also carries a 2-bit field that picks how the next microaddress is formed.

The next microaddress is one of four things: the current address plus one, address zero (instruction fetch), or a lookup of the 6-bit opcode in one of two dispatch tables. The first table chooses the execution routine after decode. The second table splits load from store after the effective address has been computed. The datapath sets the opcode from its instruction register and holds it steady while an instruction runs.

Top module: `mcode_ctrl`

## Requirements
- R1: A synchronous active-high reset loads microaddress 0, so the fetch microword appears in the first cycle after reset is released. A reset asserted in the middle of a routine takes effect at the next clock edge.
- R2: Microaddress 0 (fetch) drives pc_wr=1, mem_rd=1, ir_wr=1, addr_from_alu=0, pc_src=00, alu_op=00 (add), alu_a_sel=0 (PC) and alu_b_sel=01. The alu_b_sel encoding is 00 = register B, 01 = constant 4, 10 = sign-extended immediate, 11 = immediate shifted left by two.
- R3: Sequencing code 11 advances to the current address plus one. This applies at addresses 0, 3 and 6.
- R4: Microaddress 1 (decode) drives alu_op=00, alu_a_sel=0 and alu_b_sel=11, and then dispatches through table 1. Table 1 maps opcode 000000 to address 6, 000010 to 9, 000100 to 8, and both 100011 and 101011 to 2.
- R5: Address 2 dispatches through table 2. Table 2 maps opcode 100011 to 3 and 101011 to 5.
- R6: Sequencing code 00 returns to address 0. Addresses 4, 5, 7, 8 and 9 use it.
- R7: The memory words are as follows. Address 2 drives alu_a_sel=1, alu_b_sel=10 and alu_op=00. Address 3 drives mem_rd=1 and addr_from_alu=1. Address 4 drives rf_wr=1, rf_dst_rd=0 and wb_from_mdr=1. Address 5 drives mem_wr=1 and addr_from_alu=1.
- R8: Address 6 drives alu_op=10, alu_a_sel=1 and alu_b_sel=00. Address 7 drives rf_wr=1, rf_dst_rd=1 and wb_from_mdr=0.
- R9: Address 8 drives alu_op=01, alu_a_sel=1, alu_b_sel=00, pc_src=01 and pc_wr_cond=1. Address 9 drives pc_src=10 and pc_wr=1.
- R10: An opcode that is not listed in the selected dispatch table sends the sequencer to address 0.
- R11: Every control bit that a microword does not name is driven 0. As a result, mem_rd and mem_wr are never both 1, and pc_wr and pc_wr_cond are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the current instruction |
| pc_wr | output | 1 | Unconditional program-counter write |
| pc_wr_cond | output | 1 | Program-counter write when the ALU reports zero |
| addr_from_alu | output | 1 | Memory address from the ALU result register (1) or from the PC (0) |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register load |
| wb_from_mdr | output | 1 | Register write data from the memory data register (1) or from the ALU result (0) |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_op | output | 2 | 00 add, 01 subtract, 10 use the function field |
| alu_a_sel | output | 1 | ALU first operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU second operand, encoded as stated in R2 |
| rf_wr | output | 1 | Register file write |
| rf_dst_rd | output | 1 | Write address taken from the rd field (1) or the rt field (0) |

## Verification
The ten microwords are pairwise distinct, so the outputs identify the current microaddress in every cycle. A wrong microprogram counter or a wrong dispatch target therefore shows at the ports in the cycle right after the edge that loaded it. If a bit in a microword is corrupted, it appears in the outputs of the cycle in which that address is active. A broken sequencing path shows a moment later, as the wrong word one edge on. The bench follows the address with its own model. It compares all outputs on every clock, including after opcodes that are missing from a table and after a reset in the middle of a routine.

// File: rtl/mcode_ctrl_pkg.sv
package mcode_ctrl_pkg;

    localparam int UADDR_W   = 4;
    localparam int ROM_WORDS = 10;
    localparam int OP_W      = 6;
    localparam int NUM_TBL   = 2;

    localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'b000010;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;

    typedef logic [UADDR_W-1:0] uaddr_t;

    typedef enum logic [1:0] {
        SEQ_FETCH = 2'b00,
        SEQ_TBL1  = 2'b01,
        SEQ_TBL2  = 2'b10,
        SEQ_NEXT  = 2'b11
    } seq_e;

    typedef enum logic [1:0] {
        BSRC_REGB  = 2'b00,
        BSRC_FOUR  = 2'b01,
        BSRC_IMM   = 2'b10,
        BSRC_IMMSH = 2'b11
    } bsrc_e;

    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic       addr_from_alu;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_wr;
        logic       wb_from_mdr;
        logic [1:0] pc_src;
        logic [1:0] alu_op;
        logic       alu_a_sel;
        bsrc_e      alu_b_sel;
        logic       rf_wr;
        logic       rf_dst_rd;
        seq_e       seq;
    } uword_t;

    typedef struct packed {
        logic   hit;
        uaddr_t target;
    } disp_t;

    // Dispatch lookup: table 0 follows decode, table 1 follows address calc.
    function automatic disp_t disp_lookup(input int tbl, input logic [OP_W-1:0] op);
        disp_t r;
        r = '0;
        if (tbl == 0) begin
            unique case (op)
                OPC_RTYPE: r = '{1'b1, uaddr_t'(6)};
                OPC_JUMP:  r = '{1'b1, uaddr_t'(9)};
                OPC_BEQ:   r = '{1'b1, uaddr_t'(8)};
                OPC_LOAD,
                OPC_STORE: r = '{1'b1, uaddr_t'(2)};
                default:   r = '0;
            endcase
        end else begin
            unique case (op)
                OPC_LOAD:  r = '{1'b1, uaddr_t'(3)};
                OPC_STORE: r = '{1'b1, uaddr_t'(5)};
                default:   r = '0;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/mcode_ctrl_rom.sv
module mcode_ctrl_rom
    import mcode_ctrl_pkg::*;
(
    input  uaddr_t addr,
    output uword_t word
);
    always_comb begin
        word     = '0;
        word.seq = SEQ_FETCH;
        if (int'(addr) < ROM_WORDS) begin
            unique case (addr)
                uaddr_t'(0): begin
                    word.mem_rd    = 1'b1;
                    word.ir_wr     = 1'b1;
                    word.pc_wr     = 1'b1;
                    word.alu_b_sel = BSRC_FOUR;
                    word.seq       = SEQ_NEXT;
                end
                uaddr_t'(1): begin
                    word.alu_b_sel = BSRC_IMMSH;
                    word.seq       = SEQ_TBL1;
                end
                uaddr_t'(2): begin
                    word.alu_a_sel = 1'b1;
                    word.alu_b_sel = BSRC_IMM;
                    word.seq       = SEQ_TBL2;
                end
                uaddr_t'(3): begin
                    word.mem_rd        = 1'b1;
                    word.addr_from_alu = 1'b1;
                    word.seq           = SEQ_NEXT;
                end
                uaddr_t'(4): begin
                    word.rf_wr       = 1'b1;
                    word.wb_from_mdr = 1'b1;
                end
                uaddr_t'(5): begin
                    word.mem_wr        = 1'b1;
                    word.addr_from_alu = 1'b1;
                end
                uaddr_t'(6): begin
                    word.alu_op    = 2'b10;
                    word.alu_a_sel = 1'b1;
                    word.alu_b_sel = BSRC_REGB;
                    word.seq       = SEQ_NEXT;
                end
                uaddr_t'(7): begin
                    word.rf_wr     = 1'b1;
                    word.rf_dst_rd = 1'b1;
                end
                uaddr_t'(8): begin
                    word.alu_op     = 2'b01;
                    word.alu_a_sel  = 1'b1;
                    word.pc_src     = 2'b01;
                    word.pc_wr_cond = 1'b1;
                end
                uaddr_t'(9): begin
                    word.pc_src = 2'b10;
                    word.pc_wr  = 1'b1;
                end
                default: word = '0;
            endcase
        end
    end
endmodule

// File: rtl/mcode_ctrl_disp.sv
module mcode_ctrl_disp
    import mcode_ctrl_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output disp_t           res [NUM_TBL]
);
    for (genvar g = 0; g < NUM_TBL; g++) begin : g_tbl
        assign res[g] = disp_lookup(g, opcode);
    end
endmodule

// File: rtl/mcode_ctrl_next.sv
module mcode_ctrl_next
    import mcode_ctrl_pkg::*;
(
    input  uaddr_t cur,
    input  seq_e   seq,
    input  disp_t  res [NUM_TBL],
    output uaddr_t nxt
);
    always_comb begin
        unique case (seq)
            SEQ_NEXT:  nxt = cur + uaddr_t'(1);
            SEQ_TBL1:  nxt = res[0].hit ? res[0].target : '0;
            SEQ_TBL2:  nxt = res[1].hit ? res[1].target : '0;
            default:   nxt = '0;
        endcase
    end
endmodule

// File: rtl/mcode_ctrl.sv
module mcode_ctrl
    import mcode_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [5:0] opcode,
    output logic       pc_wr,
    output logic       pc_wr_cond,
    output logic       addr_from_alu,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       ir_wr,
    output logic       wb_from_mdr,
    output logic [1:0] pc_src,
    output logic [1:0] alu_op,
    output logic       alu_a_sel,
    output logic [1:0] alu_b_sel,
    output logic       rf_wr,
    output logic       rf_dst_rd
);
    uaddr_t upc;
    uaddr_t upc_nxt;
    uword_t uw;
    disp_t  disp_res [NUM_TBL];

    mcode_ctrl_rom u_rom (
        .addr (upc),
        .word (uw)
    );

    mcode_ctrl_disp u_disp (
        .opcode (opcode),
        .res    (disp_res)
    );

    mcode_ctrl_next u_next (
        .cur (upc),
        .seq (uw.seq),
        .res (disp_res),
        .nxt (upc_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) upc <= '0;
        else     upc <= upc_nxt;
    end

    assign pc_wr         = uw.pc_wr;
    assign pc_wr_cond    = uw.pc_wr_cond;
    assign addr_from_alu = uw.addr_from_alu;
    assign mem_rd        = uw.mem_rd;
    assign mem_wr        = uw.mem_wr;
    assign ir_wr         = uw.ir_wr;
    assign wb_from_mdr   = uw.wb_from_mdr;
    assign pc_src        = uw.pc_src;
    assign alu_op        = uw.alu_op;
    assign alu_a_sel     = uw.alu_a_sel;
    assign alu_b_sel     = uw.alu_b_sel;
    assign rf_wr         = uw.rf_wr;
    assign rf_dst_rd     = uw.rf_dst_rd;
endmodule

// File: rtl/mcode_ctrl_chk.sv
module mcode_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [5:0] opcode,
    input logic       pc_wr,
    input logic       pc_wr_cond,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       ir_wr,
    input logic       addr_from_alu,
    input logic       wb_from_mdr,
    input logic [1:0] pc_src,
    input logic [1:0] alu_b_sel,
    input logic       rf_wr
);
    // R1
    reset_to_fetch_chk: assert property (@(posedge clk)
        rst |=> (ir_wr && pc_wr && mem_rd));

    // R3
    fetch_then_decode_chk: assert property (@(posedge clk) disable iff (rst)
        ir_wr |=> (alu_b_sel == 2'b11 && !ir_wr && !mem_rd));

    // R4
    decode_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (alu_b_sel == 2'b11 && opcode == 6'b000010) |=> (pc_wr && pc_src == 2'b10));

    // R5
    load_read_then_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && addr_from_alu) |=> (rf_wr && wb_from_mdr));

    // R6
    regwrite_returns_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_wr || mem_wr || pc_wr_cond) |=> ir_wr);

    // R11
    mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R11
    pc_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pc_wr && pc_wr_cond));
endmodule

bind mcode_ctrl mcode_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .opcode        (opcode),
    .pc_wr         (pc_wr),
    .pc_wr_cond    (pc_wr_cond),
    .mem_rd        (mem_rd),
    .mem_wr        (mem_wr),
    .ir_wr         (ir_wr),
    .addr_from_alu (addr_from_alu),
    .wb_from_mdr   (wb_from_mdr),
    .pc_src        (pc_src),
    .alu_b_sel     (alu_b_sel),
    .rf_wr         (rf_wr)
);

// File: tb/mcode_ctrl_bench.sv
module mcode_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'b0;
    logic       pc_wr, pc_wr_cond, addr_from_alu, mem_rd, mem_wr, ir_wr, wb_from_mdr;
    logic [1:0] pc_src, alu_op, alu_b_sel;
    logic       alu_a_sel, rf_wr, rf_dst_rd;

    int checks = 0;
    int errors = 0;
    int m_addr = 0;
    string m_tag = "R1";
    bit done = 1'b0;

    always #10 clk = ~clk;

    mcode_ctrl u_mcode_ctrl (
        .clk(clk), .rst(rst), .opcode(opcode),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_from_alu(addr_from_alu),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .wb_from_mdr(wb_from_mdr),
        .pc_src(pc_src), .alu_op(alu_op), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
        .rf_wr(rf_wr), .rf_dst_rd(rf_dst_rd)
    );

    // Order: pc_wr pc_wr_cond addr_from_alu mem_rd mem_wr ir_wr wb_from_mdr
    //        pc_src alu_op alu_a_sel alu_b_sel rf_wr rf_dst_rd
    function automatic logic [16:0] exp_word(int a);
        case (a)
            0: return 17'b1_0_0_1_0_1_0_00_00_0_01_0_0; // R2
            1: return 17'b0_0_0_0_0_0_0_00_00_0_11_0_0; // R4
            2: return 17'b0_0_0_0_0_0_0_00_00_1_10_0_0; // R7
            3: return 17'b0_0_1_1_0_0_0_00_00_0_00_0_0; // R7
            4: return 17'b0_0_0_0_0_0_1_00_00_0_00_1_0; // R7
            5: return 17'b0_0_1_0_1_0_0_00_00_0_00_0_0; // R7
            6: return 17'b0_0_0_0_0_0_0_00_10_1_00_0_0; // R8
            7: return 17'b0_0_0_0_0_0_0_00_00_0_00_1_1; // R8
            8: return 17'b0_1_0_0_0_0_0_01_01_1_00_0_0; // R9
            9: return 17'b1_0_0_0_0_0_0_10_00_0_00_0_0; // R9
            default: return 17'b0;
        endcase
    endfunction

    function automatic string word_tag(int a);
        if (a == 0) return "R2";
        if (a == 1) return "R4";
        if (a <= 5) return "R7";
        if (a <= 7) return "R8";
        return "R9";
    endfunction

    task automatic model_step(logic r, logic [5:0] op);
        int n;
        string t;
        n = 0;
        t = "R6";
        if (r) begin
            n = 0; t = "R1";
        end else begin
            case (m_addr)
                0, 3, 6: begin n = m_addr + 1; t = "R3"; end
                1: begin
                    t = "R4";
                    case (op)
                        6'b000000: n = 6;
                        6'b000010: n = 9;
                        6'b000100: n = 8;
                        6'b100011, 6'b101011: n = 2;
                        default: begin n = 0; t = "R10"; end
                    endcase
                end
                2: begin
                    t = "R5";
                    case (op)
                        6'b100011: n = 3;
                        6'b101011: n = 5;
                        default: begin n = 0; t = "R10"; end
                    endcase
                end
                default: begin n = 0; t = "R6"; end
            endcase
        end
        m_addr = n;
        m_tag  = t;
    endtask

    // One clock: compare at the falling edge, drive, then advance the model.
    task automatic step(logic r, logic [5:0] op);
        logic [16:0] act;
        @(negedge clk);
        act = {pc_wr, pc_wr_cond, addr_from_alu, mem_rd, mem_wr, ir_wr, wb_from_mdr,
               pc_src, alu_op, alu_a_sel, alu_b_sel, rf_wr, rf_dst_rd};
        checks++;
        if (act !== exp_word(m_addr)) begin
            errors++;
            $display("FAIL %s/%s addr %0d actual %b expected %b",
                     m_tag, word_tag(m_addr), m_addr, act, exp_word(m_addr));
        end
        rst    = r;
        opcode = op;
        @(posedge clk);
        #1 model_step(r, op);
    endtask

    task automatic run(logic [5:0] op, int n);
        for (int i = 0; i < n; i++) step(1'b0, op);
    endtask

    initial begin
        logic [7:0] lfsr;
        logic [5:0] pick;
        lfsr = 8'hA5;
        @(posedge clk);
        #1 model_step(1'b1, 6'b0);
        step(1'b1, 6'b0);           // R1: reset held
        run(6'b000000, 5);          // R-type: 0 1 6 7 0
        run(6'b100011, 6);          // load:  0 1 2 3 4 0
        run(6'b101011, 5);          // store: 0 1 2 5 0
        run(6'b000100, 4);          // beq
        run(6'b000010, 4);          // jump
        run(6'b111111, 3);          // R10: unknown at decode
        step(1'b0, 6'b100011);      // addr 0
        step(1'b0, 6'b100011);      // addr 1 -> 2
        step(1'b0, 6'b000100);      // R10: table 2 miss -> 0
        step(1'b0, 6'b000000);
        run(6'b000000, 2);          // reach 6
        step(1'b1, 6'b000000);      // R1: reset mid-routine
        run(6'b000000, 3);
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            case (lfsr[2:0])
                3'd0: pick = 6'b000000;
                3'd1: pick = 6'b000010;
                3'd2: pick = 6'b000100;
                3'd3: pick = 6'b100011;
                3'd4: pick = 6'b101011;
                default: pick = lfsr[7:2];
            endcase
            step(lfsr[7:0] == 8'h3C, pick);
        end
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule